// File: doc/BRIEF.md
# Byte-Serial Frame Check Sequence Engine

This block computes a 16-bit frame check sequence over a stream of bytes that a host supplies one write at a time through a small 16-bit register port. It uses the reflected CCITT polynomial x^16 + x^12 + x^5 + 1 (0x8408 in shift-right form). The running register starts from 0xFFFF. The value returned as the final check sequence is the running register inverted, which is the form an infrared serial link appends to its frames. A saturating 12-bit tally counts the bytes taken in since the last clear, so the host can confirm that every byte it fed was absorbed.

The host clears the engine through the control register, feeds bytes through the feed register, and reads back either the running register or the finished check value. Each fed byte is folded into the running register in the clock edge that accepts the write, so there is no busy state. A known four-byte vector gives a fixed result, and the host can use it as a power-up self test.

Register map (word addresses on `wr_addr` / `rd_addr`):

- 0 CTRL: a write with bit 15 set clears the engine. A read returns the tally in bits [11:0], with bits [15:12] reading 0.
- 1 FEED: a write takes in bits [7:0] as one byte. A read returns 0.
- 2 RAW: the running register, read only.
- 3 FCS: the running register inverted, read only.

Top module: `fcs16_engine`

## Requirements
- R1: After reset, CTRL reads 0x0000, RAW reads 0xFFFF and FCS reads 0x0000.
- R2: A CTRL write with bit 15 = 1 returns RAW to 0xFFFF and the tally to 0, whatever came before.
- R3: A CTRL write with bit 15 = 0 changes neither the tally nor RAW.
- R4: CTRL bits [15:12] always read 0, so the clear bit never reads back as set.
- R5: A FEED write folds bits [7:0] of the write data into RAW, shifting right with polynomial 0x8408, and adds one to the tally. Bits [15:8] of the write data have no effect.
- R6: FEED writes on consecutive clock cycles are each absorbed, one byte per cycle, with no stall and no lost byte.
- R7: After a clear, feeding 0xCC, 0xF5, 0xF1, 0xA7 gives a tally of 4 and an FCS of 0x51DF.
- R8: FCS always reads as RAW XOR 0xFFFF.
- R9: The tally stops at 0xFFF. Further FEED writes leave it at 0xFFF while RAW keeps absorbing bytes.
- R10: Writes to the RAW or FCS addresses change neither the tally nor RAW. A FEED address read returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe, one register write per cycle |
| wr_addr | input | 2 | Word address of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 2 | Word address of the read |
| rd_data | output | 16 | Read data, combinational from rd_addr and register state |

## Verification
The read path is combinational from the state registers, so a wrong running value or tally shows at `rd_data` one cycle after the write that caused it. It also stays visible until the next clear, because every later byte is folded on top of the error. One wrong bit in a single fold step therefore shows up in the FCS of every longer vector. A tally that wraps instead of saturating shows as 0x000 on the 4096th byte. A clear that fails to act shows as a nonzero tally on the next read.

// File: rtl/fcs16_pkg.sv
package fcs16_pkg;

  localparam int unsigned REG_W  = 16;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 2'd0,
    REG_FEED = 2'd1,
    REG_RAW  = 2'd2,
    REG_FCS  = 2'd3
  } fcs_reg_e;

  // bit of the control word that requests a clear
  localparam int unsigned CLR_BIT = 15;

endpackage

// File: rtl/fcs16_byte_fold.sv
// Combinational fold of one byte into the running register, one stage per bit.
module fcs16_byte_fold #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY = 16'h8408
) (
  input  logic [CRC_W-1:0]  crc_in,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_out
);
  logic [CRC_W-1:0] stage [BYTE_W+1];

  assign stage[0] = crc_in ^ {{(CRC_W-BYTE_W){1'b0}}, byte_in};

  for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
    assign stage[b+1] = stage[b][0] ? ((stage[b] >> 1) ^ POLY) : (stage[b] >> 1);
  end

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/fcs16_state.sv
// Running check register with clear and absorb enables.
module fcs16_state #(
  parameter int unsigned CRC_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter logic [CRC_W-1:0] POLY   = 16'h8408,
  parameter logic [CRC_W-1:0] PRESET = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              absorb,
  input  logic [BYTE_W-1:0] byte_in,
  output logic [CRC_W-1:0]  crc_q
);
  logic [CRC_W-1:0] folded;
  logic [CRC_W-1:0] crc_d;
  logic             crc_en;

  fcs16_byte_fold #(.CRC_W(CRC_W), .BYTE_W(BYTE_W), .POLY(POLY)) fold_i (
    .crc_in (crc_q),
    .byte_in(byte_in),
    .crc_out(folded)
  );

  always_comb begin
    crc_en = clr | absorb;
    crc_d  = clr ? PRESET : folded;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= PRESET;
    else if (crc_en) crc_q <= crc_d;
  end
endmodule

// File: rtl/fcs16_byte_tally.sv
// Saturating count of bytes absorbed since the last clear.
module fcs16_byte_tally #(
  parameter int unsigned CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr | (inc && (cnt_q != CNT_MAX));
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/fcs16_engine.sv
module fcs16_engine #(
  parameter int unsigned CNT_W  = 12,
  parameter logic [15:0] POLY   = 16'h8408,
  parameter logic [15:0] PRESET = 16'hFFFF,
  parameter logic [15:0] XOROUT = 16'hFFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_addr,
  input  logic [15:0] wr_data,
  input  logic [1:0]  rd_addr,
  output logic [15:0] rd_data
);
  import fcs16_pkg::*;

  logic [1:0]        rst_sync;
  logic              rst_sync_n;
  logic              clr;
  logic              feed;
  logic [REG_W-1:0]  crc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              unused_wr_bits;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  always_comb begin
    clr  = wr_en && (fcs_reg_e'(wr_addr) == REG_CTRL) && wr_data[CLR_BIT];
    feed = wr_en && (fcs_reg_e'(wr_addr) == REG_FEED);
  end

  assign unused_wr_bits = ^wr_data[CLR_BIT-1:BYTE_W];

  fcs16_state #(
    .CRC_W(REG_W), .BYTE_W(BYTE_W), .POLY(POLY), .PRESET(PRESET)
  ) state_i (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .clr    (clr),
    .absorb (feed),
    .byte_in(wr_data[BYTE_W-1:0]),
    .crc_q  (crc_q)
  );

  fcs16_byte_tally #(.CNT_W(CNT_W)) tally_i (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .clr  (clr),
    .inc  (feed),
    .cnt_q(cnt_q)
  );

  always_comb begin
    rd_data = '0;
    case (fcs_reg_e'(rd_addr))
      REG_CTRL: rd_data[CNT_W-1:0] = cnt_q;
      REG_RAW:  rd_data = crc_q;
      REG_FCS:  rd_data = crc_q ^ XOROUT;
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/fcs16_engine_chk.sv
module fcs16_engine_chk #(
  parameter int unsigned CNT_W  = 12,
  parameter logic [15:0] PRESET = 16'hFFFF,
  parameter logic [15:0] XOROUT = 16'hFFFF
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [15:0]      wr_data,
  input logic [1:0]       rd_addr,
  input logic [15:0]      rd_data,
  input logic [15:0]      crc_q,
  input logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic wr_clr;
  logic wr_feed;
  assign wr_clr  = wr_en && (wr_addr == 2'd0) && wr_data[15];
  assign wr_feed = wr_en && (wr_addr == 2'd1);

  // R2
  clear_restores_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> (cnt_q == '0) && (crc_q == PRESET));

  // R3
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_clr && !wr_feed) |=> $stable(crc_q) && $stable(cnt_q));

  // R4
  ctrl_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd0) |-> (rd_data[15:CNT_W] == '0));

  // R5
  feed_counts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_feed && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + 1'b1));

  // R8
  fcs_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr == 2'd3) |-> (rd_data == (crc_q ^ XOROUT)));

  // R9
  tally_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_feed && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

bind fcs16_engine fcs16_engine_chk #(
  .CNT_W(CNT_W), .PRESET(PRESET), .XOROUT(XOROUT)
) chk_i (
  .clk    (clk),
  .rst_n  (rst_sync_n),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .wr_data(wr_data),
  .rd_addr(rd_addr),
  .rd_data(rd_data),
  .crc_q  (crc_q),
  .cnt_q  (cnt_q)
);

// File: tb/fcs16_engine_tb_top.sv
`timescale 1ns/1ps
module fcs16_engine_tb_top;
  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [1:0]  rd_addr;
  logic [15:0] rd_data;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  logic [15:0] model_crc;
  logic [11:0] model_cnt;

  fcs16_engine dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  initial clk = 0;
  always #2.5 clk = ~clk;

  function automatic logic [15:0] ref_fold(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c;
    for (int i = 0; i < 8; i++) begin
      if ((r[0] ^ b[i]) == 1'b1) r = (r >> 1) ^ 16'h8408;
      else                       r = r >> 1;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    #1 d = rd_data;
  endtask

  task automatic feed(input logic [7:0] b, input logic [7:0] hi);
    wr(2'd1, {hi, b});
    model_crc = ref_fold(model_crc, b);
    if (model_cnt != 12'hFFF) model_cnt++;
  endtask

  task automatic clear_all();
    wr(2'd0, 16'h8000);
    model_crc = 16'hFFFF; model_cnt = 0;
  endtask

  task automatic check_state(input string req);
    logic [15:0] v;
    rd(2'd0, v); check(req, v, {4'h0, model_cnt});
    rd(2'd2, v); check(req, v, model_crc);
    rd(2'd3, v); check(req, v, ~model_crc);
  endtask

  task automatic t_reset_state();
    logic [15:0] v;
    rd(2'd0, v); check("R1 ctrl", v, 16'h0000);
    rd(2'd2, v); check("R1 raw", v, 16'hFFFF);
    rd(2'd3, v); check("R1 fcs", v, 16'h0000);
  endtask

  task automatic t_selftest();
    logic [15:0] v;
    clear_all();
    feed(8'hCC, 8'h00); feed(8'hF5, 8'h00); feed(8'hF1, 8'h00); feed(8'hA7, 8'h00);
    rd(2'd0, v); check("R7 count", v, 16'h0004);
    rd(2'd3, v); check("R7 fcs", v, 16'h51DF);
    rd(2'd2, v); check("R8 raw", v, 16'hAE20);
  endtask

  task automatic t_upper_ignored();
    clear_all();
    feed(8'h5A, 8'hFF); feed(8'h00, 8'hA5); feed(8'hFF, 8'h3C);
    check_state("R5 upper bits");
  endtask

  task automatic t_ctrl_noclear();
    clear_all();
    feed(8'h12, 8'h00); feed(8'h34, 8'h00);
    wr(2'd0, 16'h7FFF);
    check_state("R3 no clear");
  endtask

  task automatic t_ctrl_readback();
    logic [15:0] v;
    wr(2'd0, 16'hFFFF);
    model_crc = 16'hFFFF; model_cnt = 0;
    rd(2'd0, v); check("R4 ctrl high", v, 16'h0000);
    check_state("R2 clear");
  endtask

  task automatic t_ro_writes();
    logic [15:0] v;
    clear_all();
    feed(8'h9C, 8'h00);
    wr(2'd2, 16'h1234);
    wr(2'd3, 16'hBEEF);
    check_state("R10 ro write");
    rd(2'd1, v); check("R10 feed read", v, 16'h0000);
  endtask

  task automatic t_back_to_back();
    clear_all();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = 2'd1; wr_data = {8'hEE, 8'(i * 37 + 3)};
      model_crc = ref_fold(model_crc, 8'(i * 37 + 3));
      model_cnt++;
    end
    @(negedge clk);
    wr_en = 0;
    check_state("R6 back to back");
  endtask

  task automatic t_clear_midstream();
    clear_all();
    feed(8'hAA, 8'h00); feed(8'h55, 8'h00); feed(8'h01, 8'h00);
    clear_all();
    check_state("R2 mid clear");
    feed(8'hCC, 8'h00); feed(8'hF5, 8'h00); feed(8'hF1, 8'h00); feed(8'hA7, 8'h00);
    check_state("R7 after mid clear");
  endtask

  task automatic t_saturate();
    logic [15:0] v;
    clear_all();
    for (int i = 0; i < 4095; i++) begin
      @(negedge clk);
      wr_en = 1; wr_addr = 2'd1; wr_data = {8'h00, 8'(i)};
      model_crc = ref_fold(model_crc, 8'(i));
      model_cnt++;
    end
    @(negedge clk);
    wr_en = 0;
    rd(2'd0, v); check("R9 at max", v, 16'h0FFF);
    feed(8'h11, 8'h00); feed(8'h22, 8'h00); feed(8'h33, 8'h00);
    check_state("R9 saturated");
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
    model_crc = 16'hFFFF; model_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    t_reset_state();
    t_selftest();
    t_upper_ignored();
    t_ctrl_noclear();
    t_ctrl_readback();
    t_ro_writes();
    t_back_to_back();
    t_clear_midstream();
    t_saturate();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule